// File: doc/BRIEF.md
# Bypassable Clock-Enable Divider with Safe Reprogramming

This block turns a stream of source clock-enable pulses into a slower output enable that fires once every N source pulses, where N comes from an 8-bit divisor field. A bypass path can route a crystal reference enable straight to the output in place of the divided stream. Software sets bypass through a one-bit register write. A divisor write does not reach the divider directly. A short sequencer first forces bypass on, then loads the divisor. It then waits a settle time, measured in reference pulses, and only after that hands the output back to the divider.

A divisor field of zero stands for a ratio of 256. A requested ratio that does not fit the field saturates to that same encoding. The ratio currently in effect is available as a 9-bit value. When the source of this slice is itself a divider that is bypassed, the `up_byp` input makes the slice count reference pulses in place of source pulses. Divisor writes that arrive while the sequencer is busy are dropped.

Top module: `clkdiv_byp`

## Requirements
- R1: A requested ratio from 1 to 255 is stored as that value. A request of 0, or of 256 or more, is stored as field 0. `eff_ratio` shows 256 for field 0 and the field value otherwise.
- R2: When not bypassed, the division counts one tick per effective source pulse. `out_clk_en` is high in the same cycle as every Nth tick and low on all other ticks, where N is `eff_ratio`. The count starts from zero whenever bypass ends.
- R3: A write with `wr_byp_en` high stores `wr_byp_val` as the software bypass bit. While bypass is in effect, `out_clk_en` equals `ref_clk_en` in the same cycle.
- R4: After reset, `busy` is 0, `eff_ratio` is 256 and software bypass is 1.
- R5: A divisor write taken while idle raises `busy` from the next clock edge. While `busy` is high, bypass is forced on whatever the software bypass bit holds.
- R6: The new ratio appears on `eff_ratio` at the second clock edge after the write is taken. It is unchanged after the first edge.
- R7: After the load, `busy` stays high until SETTLE_REFS `ref_clk_en` pulses have been sampled. It falls at the edge that samples the last of them and cannot fall without one.
- R8: A divisor write made while `busy` is high has no effect on `eff_ratio` or on the sequence in progress.
- R9: Reprogramming discards any partial count. After the sequence ends, the first output pulse comes on the Nth new tick.
- R10: When `up_byp` is 1, the divider counts `ref_clk_en` pulses and ignores `src_clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_en | input | 1 | Crystal reference enable pulse |
| src_clk_en | input | 1 | Source enable pulse to be divided |
| up_byp | input | 1 | Upstream divider is bypassed; count reference pulses instead |
| wr_div_en | input | 1 | Divisor write strobe |
| wr_ratio | input | REQ_W (12) | Requested divide ratio |
| wr_byp_en | input | 1 | Bypass bit write strobe |
| wr_byp_val | input | 1 | Bypass bit value |
| out_clk_en | output | 1 | Output enable pulse |
| busy | output | 1 | Reprogramming sequence in progress |
| eff_ratio | output | FIELD_W+1 (9) | Ratio currently in effect (1 to 256) |

## Verification
`out_clk_en` is combinational from the enables, so the bench samples it 1 ns after driving an input at the falling edge, before the next rising edge. `busy` is registered. It is checked at the first falling edge after a write is taken, and its fall is timed as the falling edge that follows SETTLE_REFS+1 rising edges. `eff_ratio` is checked after one edge, where it must still hold the old value, and after two edges, where it must show the new one. The division checks count tick by tick and expect pulses on exactly the Nth and 2Nth ticks.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FORCE  = 2'd1,
    SEQ_SETTLE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
#(
  parameter int REQ_W       = 12,
  parameter int FIELD_W     = 8,
  parameter int SETTLE_REFS = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_en,
  input  logic               wr_div_en,
  input  logic [REQ_W-1:0]   wr_req,
  output logic               busy,
  output logic [FIELD_W-1:0] field_q
);

  localparam int unsigned FULL_RATIO = 1 << FIELD_W;
  localparam int          SC_W       = $clog2(SETTLE_REFS + 1);
  localparam logic [SC_W-1:0] LAST_REF = SC_W'(SETTLE_REFS - 1);

  seq_state_e         state_q, state_d;
  logic [FIELD_W-1:0] pend_q, pend_d;
  logic [FIELD_W-1:0] field_d;
  logic [SC_W-1:0]    scnt_q, scnt_d;
  logic [FIELD_W-1:0] enc;

  // saturate out-of-range requests to the all-zero (256) encoding
  always_comb begin
    if ((wr_req == '0) || (32'(wr_req) >= FULL_RATIO)) enc = '0;
    else                                               enc = wr_req[FIELD_W-1:0];
  end

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    field_d = field_q;
    scnt_d  = scnt_q;
    case (state_q)
      SEQ_IDLE: begin
        if (wr_div_en) begin
          pend_d  = enc;
          state_d = SEQ_FORCE;
        end
      end
      SEQ_FORCE: begin
        field_d = pend_q;
        scnt_d  = '0;
        state_d = SEQ_SETTLE;
      end
      SEQ_SETTLE: begin
        if (ref_en) begin
          if (scnt_q == LAST_REF) state_d = SEQ_IDLE;
          else                    scnt_d  = scnt_q + SC_W'(1);
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
      field_q <= '0;
      scnt_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      field_q <= field_d;
      scnt_q  <= scnt_d;
    end
  end

  assign busy = (state_q != SEQ_IDLE);

  // R7
  settle_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ref_en));

  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_div_en && !busy) |=> (state_q == SEQ_FORCE));

  // R6
  load_only_after_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q != $past(field_q)) |-> ($past(state_q) == SEQ_FORCE));

  // R8
  no_load_in_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_SETTLE) |=> $stable(field_q));

endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count #(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               tick,
  input  logic [FIELD_W-1:0] field,
  output logic [FIELD_W:0]   ratio,
  output logic               pulse
);

  localparam int RATIO_W = FIELD_W + 1;
  localparam logic [RATIO_W-1:0] FULL = RATIO_W'(1) << FIELD_W;

  logic [FIELD_W-1:0] cnt_q, cnt_d;
  logic               hit;

  assign ratio = (field == '0) ? FULL : {1'b0, field};
  assign hit   = ({1'b0, cnt_q} == (ratio - RATIO_W'(1)));
  assign pulse = tick && !clr && hit;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = hit ? '0 : (cnt_q + FIELD_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} < ratio));

  // R9
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/clkdiv_byp.sv
module clkdiv_byp #(
  parameter int REQ_W       = 12,
  parameter int FIELD_W     = 8,
  parameter int SETTLE_REFS = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_clk_en,
  input  logic               src_clk_en,
  input  logic               up_byp,
  input  logic               wr_div_en,
  input  logic [REQ_W-1:0]   wr_ratio,
  input  logic               wr_byp_en,
  input  logic               wr_byp_val,
  output logic               out_clk_en,
  output logic               busy,
  output logic [FIELD_W:0]   eff_ratio
);

  logic               byp_q, byp_d;
  logic               byp_eff;
  logic               tick;
  logic               div_pulse;
  logic [FIELD_W-1:0] field;

  always_comb begin
    byp_d = byp_q;
    if (wr_byp_en) byp_d = wr_byp_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b1;
    else        byp_q <= byp_d;
  end

  clkdiv_seq #(
    .REQ_W      (REQ_W),
    .FIELD_W    (FIELD_W),
    .SETTLE_REFS(SETTLE_REFS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_clk_en),
    .wr_div_en(wr_div_en),
    .wr_req   (wr_ratio),
    .busy     (busy),
    .field_q  (field)
  );

  // upstream bypassed: the reference stands in for the source
  assign tick    = up_byp ? ref_clk_en : src_clk_en;
  assign byp_eff = byp_q | busy;

  clkdiv_count #(
    .FIELD_W(FIELD_W)
  ) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (byp_eff),
    .tick (tick),
    .field(field),
    .ratio(eff_ratio),
    .pulse(div_pulse)
  );

  assign out_clk_en = byp_eff ? ref_clk_en : div_pulse;

  // R5
  forced_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (out_clk_en == ref_clk_en));

  // R1
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_ratio != '0) && (eff_ratio <= ((FIELD_W+1)'(1) << FIELD_W)));

endmodule

// File: tb/sim_clkdiv_byp.sv
`timescale 1ns/1ps
module sim_clkdiv_byp;

  localparam int REQ_W  = 12;
  localparam int FW     = 8;
  localparam int SETTLE = 20;
  localparam int NVEC   = 9;
  localparam int VEC_REQ [NVEC] = '{1, 2, 3, 7, 255, 256, 300, 0, 4095};
  localparam int VEC_EXP [NVEC] = '{1, 2, 3, 7, 255, 256, 256, 256, 256};

  logic clk = 1'b0;
  logic rst_n;
  logic ref_clk_en, src_clk_en, up_byp;
  logic wr_div_en, wr_byp_en, wr_byp_val;
  logic [REQ_W-1:0] wr_ratio;
  logic out_clk_en, busy;
  logic [FW:0] eff_ratio;

  int checks = 0;
  int failures = 0;
  int prev_ratio;

  always #5 clk = ~clk;

  clkdiv_byp #(.REQ_W(REQ_W), .FIELD_W(FW), .SETTLE_REFS(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk_en(ref_clk_en), .src_clk_en(src_clk_en),
    .up_byp(up_byp), .wr_div_en(wr_div_en), .wr_ratio(wr_ratio),
    .wr_byp_en(wr_byp_en), .wr_byp_val(wr_byp_val),
    .out_clk_en(out_clk_en), .busy(busy), .eff_ratio(eff_ratio));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_div(input int req);
    @(negedge clk);
    wr_div_en = 1'b1;
    wr_ratio  = REQ_W'(req);
    @(negedge clk);
    wr_div_en = 1'b0;
  endtask

  task automatic wr_byp(input bit v);
    @(negedge clk);
    wr_byp_en  = 1'b1;
    wr_byp_val = v;
    @(negedge clk);
    wr_byp_en = 1'b0;
  endtask

  task automatic settle();
    ref_clk_en = 1'b1;
    for (int k = 0; k < 4 * SETTLE && busy; k++) @(negedge clk);
    ref_clk_en = 1'b0;
  endtask

  task automatic div_run(input int n, input bit via_ref, input string tag);
    int bad = 0;
    for (int i = 1; i <= 2 * n; i++) begin
      @(negedge clk);
      if (via_ref) ref_clk_en = 1'b1; else src_clk_en = 1'b1;
      #1;
      if (out_clk_en !== ((i == n) || (i == 2 * n))) bad++;
    end
    @(negedge clk);
    ref_clk_en = 1'b0;
    src_clk_en = 1'b0;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int fall_at;
    rst_n = 1'b0;
    ref_clk_en = 0; src_clk_en = 0; up_byp = 0;
    wr_div_en = 0; wr_ratio = '0; wr_byp_en = 0; wr_byp_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    chk(busy == 1'b0, "R4 busy", busy, 0);
    chk(eff_ratio == 256, "R4 eff_ratio", eff_ratio, 256);
    ref_clk_en = 1'b1; #1;
    chk(out_clk_en == 1'b1, "R4 bypass follows ref high", out_clk_en, 1);
    ref_clk_en = 1'b0; src_clk_en = 1'b1; #1;
    chk(out_clk_en == 1'b0, "R4 bypass follows ref low", out_clk_en, 0);
    src_clk_en = 1'b0;

    // R3 clear software bypass: ref no longer reaches output
    wr_byp(1'b0);
    ref_clk_en = 1'b1; #1;
    chk(out_clk_en == 1'b0, "R3 bypass off ignores ref", out_clk_en, 0);
    ref_clk_en = 1'b0;

    // vector table: R1 R2 R5 R6 R7
    prev_ratio = 256;
    for (int v = 0; v < NVEC; v++) begin
      wr_div(VEC_REQ[v]);
      chk(busy == 1'b1, "R5 busy after write", busy, 1);
      chk(eff_ratio == prev_ratio, "R6 old ratio after first edge", eff_ratio, prev_ratio);
      ref_clk_en = 1'b1;
      fall_at = -1;
      for (int k = 1; k <= 4 * SETTLE; k++) begin
        @(negedge clk);
        if (k == 1) chk(eff_ratio == VEC_EXP[v], "R1 R6 ratio after load", eff_ratio, VEC_EXP[v]);
        if (!busy) begin fall_at = k; break; end
      end
      ref_clk_en = 1'b0;
      chk(fall_at == SETTLE + 1, "R7 settle length", fall_at, SETTLE + 1);
      div_run(VEC_EXP[v], 1'b0, "R2 divided pulses");
      prev_ratio = VEC_EXP[v];
    end

    // R7 / R5 / R8 directed: reference held off keeps busy
    wr_div(5);
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R7 busy waits for ref", busy, 1);
    ref_clk_en = 1'b1; #1;
    chk(out_clk_en == 1'b1, "R5 forced bypass ref high", out_clk_en, 1);
    ref_clk_en = 1'b0; src_clk_en = 1'b1; #1;
    chk(out_clk_en == 1'b0, "R5 forced bypass src ignored", out_clk_en, 0);
    src_clk_en = 1'b0;
    wr_div(9);
    for (int p = 0; p < SETTLE - 1; p++) begin
      @(negedge clk) ref_clk_en = 1'b1;
      @(negedge clk) ref_clk_en = 1'b0;
    end
    chk(busy == 1'b1, "R7 busy before last ref", busy, 1);
    @(negedge clk) ref_clk_en = 1'b1;
    @(negedge clk) ref_clk_en = 1'b0;
    chk(busy == 1'b0, "R7 busy after last ref", busy, 0);
    chk(eff_ratio == 5, "R8 write during busy ignored", eff_ratio, 5);
    div_run(5, 1'b0, "R8 ratio still five");

    // R9 restart on reprogram
    for (int p = 0; p < 3; p++) begin
      @(negedge clk) src_clk_en = 1'b1;
      #1 chk(out_clk_en == 1'b0, "R9 partial count no pulse", out_clk_en, 0);
    end
    @(negedge clk) src_clk_en = 1'b0;
    wr_div(5);
    settle();
    div_run(5, 1'b0, "R9 count restarted");

    // R10 upstream bypass counts reference
    up_byp = 1'b1;
    div_run(5, 1'b1, "R10 ref as source");
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk) src_clk_en = 1'b1;
        #1 if (out_clk_en) seen++;
      end
      @(negedge clk) src_clk_en = 1'b0;
      chk(seen == 0, "R10 src ignored", seen, 0);
    end
    up_byp = 1'b0;

    // R3 software bypass on at run time
    wr_byp(1'b1);
    src_clk_en = 1'b1; #1;
    chk(out_clk_en == 1'b0, "R3 bypass blocks src", out_clk_en, 0);
    src_clk_en = 1'b0; ref_clk_en = 1'b1; #1;
    chk(out_clk_en == 1'b1, "R3 bypass passes ref", out_clk_en, 1);
    ref_clk_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule